// File: doc/BRIEF.md
# Key-Sequenced 64-Bit Watchdog Timer

This block is a bus-mapped watchdog. It counts on a 64-bit up-counter that is split into two 32-bit halves, and it compares the count with a 64-bit period register split the same way. The counter advances on every clock cycle in which the tick input is high. When the count reaches the period, the block raises a sticky timeout flag and drives a reset pulse of fixed length.

Software first sets the period and selects the 64-bit watchdog mode in the global control register. It then arms the watchdog with two ordered key writes to the watchdog control register. The first accepted key locks all configuration. The second key starts the count.

While the watchdog runs, software keeps it alive by writing the same two keys in order, which clears the counter. A key value that does not match the one expected next is treated as a fault and forces an immediate timeout. Only the block's reset input returns it to the idle, unlocked state.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the reset output is low. The ID word at byte offset 0x00 reads the ID_VALUE parameter, offset 0x04 reads zero, and the watchdog control register at 0x28 reads zero.
- R2: While idle, the counter halves (low 0x10, high 0x14), period halves (low 0x18, high 0x1C), timer control (0x20) and global control (0x24) read back the last value written.
- R3: A write to 0x28 with 0xA5C6 in bits 31:16 and bit 14 set moves the block from idle to pre-active, provided global control bits 3:0 equal 4'b1011. Without bit 14, or without that global control value, the write has no effect. Bit 14 of 0x28 reads 1 from pre-active onward.
- R4: In pre-active, a write to 0x28 with 0xDA7E in bits 31:16 and bit 14 set enters the active state and clears the counter to zero.
- R5: Outside idle, writes to offsets 0x10 through 0x24 are ignored, and bit 14 of 0x28 cannot be cleared.
- R6: In the active and service states, the counter increments by one on each cycle with tick high. It holds when tick is low. It never counts in idle or pre-active.
- R7: A ticked cycle in which the full 64-bit counter equals the 64-bit period is a timeout. It sets the flag at bit 15 of 0x28, restarts the counter at zero, and raises the reset output after that edge. With period P, the output rises P+1 ticked cycles after the arming write, and a nonzero period high half delays the timeout accordingly.
- R8: After a timeout the reset output stays high for exactly RST_CYCLES cycles.
- R9: In the active state, a write of key 0xA5C6 enters the service state. A following write of key 0xDA7E returns the block to active and clears the counter to zero.
- R10: In the active or service state, a write to 0x28 whose bits 31:16 are nonzero and differ from the key expected next causes a timeout at that edge. A write whose key field is 0x0000 is not a key write.
- R11: Writing 1 to bit 15 of 0x28 clears the timeout flag in any state.
- R12: Once active, no bus write returns the block to idle. Only the reset input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable for the watchdog counter |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| wdog_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The bench builds the block with RST_CYCLES set to 4, which selects the down-counter pulse variant and keeps the pulse short enough to measure edge by edge. It also sets a distinctive ID_VALUE so that the ID read shows the parameter arriving at the port. The periods it programs are small (0, 5, 10), so timeouts, period-zero behaviour and service restarts all fall within a few cycles. A period with a nonzero high half shows that the comparison spans all 64 bits. The single-flop pulse variant (RST_CYCLES of 1) is not built by this bench.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;
   localparam int WD_DW = 32;
   localparam int WD_KW = 16;
   localparam int WD_NH = 2;

   typedef enum logic [1:0] {
      WD_IDLE = 2'd0,
      WD_PRE  = 2'd1,
      WD_RUN  = 2'd2,
      WD_SVC  = 2'd3
   } wd_state_e;

   localparam logic [7:0] OFF_ID   = 8'h00;
   localparam logic [7:0] OFF_EMU  = 8'h04;
   localparam logic [7:0] OFF_CLO  = 8'h10;
   localparam logic [7:0] OFF_CHI  = 8'h14;
   localparam logic [7:0] OFF_PLO  = 8'h18;
   localparam logic [7:0] OFF_PHI  = 8'h1C;
   localparam logic [7:0] OFF_TCTL = 8'h20;
   localparam logic [7:0] OFF_GCTL = 8'h24;
   localparam logic [7:0] OFF_WCTL = 8'h28;

   localparam int BIT_EN   = 14;
   localparam int BIT_FLAG = 15;

   // both halves released from reset, 64-bit watchdog mode
   localparam logic [3:0] GCTL_ARM = 4'b1011;
endpackage

// File: rtl/kwd_keyfsm.sv
`timescale 1ns/1ps
module kwd_keyfsm
   import kwd_pkg::*;
#(
   parameter logic [WD_KW-1:0] KEY_A = 16'hA5C6,
   parameter logic [WD_KW-1:0] KEY_B = 16'hDA7E
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr_i,
   input  logic [WD_KW-1:0] key_i,
   input  logic             en_bit_i,
   input  logic             mode_ok_i,
   output wd_state_e        state_o,
   output logic             arm_done_o,
   output logic             svc_done_o,
   output logic             bad_key_o
);
   wd_state_e st_q, st_d;
   logic is_a, is_b;

   assign is_a = (key_i == KEY_A);
   assign is_b = (key_i == KEY_B);

   always_comb begin
      st_d       = st_q;
      arm_done_o = 1'b0;
      svc_done_o = 1'b0;
      bad_key_o  = 1'b0;
      case (st_q)
         WD_IDLE: if (key_wr_i && is_a && en_bit_i && mode_ok_i) st_d = WD_PRE;
         WD_PRE: begin
            if (key_wr_i && is_b && en_bit_i) begin
               st_d       = WD_RUN;
               arm_done_o = 1'b1;
            end
         end
         WD_RUN: begin
            if (key_wr_i) begin
               if (is_a) st_d = WD_SVC;
               else      bad_key_o = 1'b1;
            end
         end
         default: begin
            if (key_wr_i) begin
               if (is_b) begin
                  st_d       = WD_RUN;
                  svc_done_o = 1'b1;
               end else begin
                  bad_key_o = 1'b1;
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= WD_IDLE;
      else        st_q <= st_d;
   end

   assign state_o = st_q;

   // R12: a running watchdog never falls back to idle or pre-active
   assert_no_disarm_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == WD_RUN || st_q == WD_SVC) |=> (st_q == WD_RUN || st_q == WD_SVC));

   // R3: leaving idle needs the first key with the enable bit
   assert_arm_needs_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == WD_IDLE && !(key_wr_i && is_a && en_bit_i)) |=> st_q == WD_IDLE);

   // R4: pre-active only ever advances to active
   assert_pre_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == WD_PRE) |=> (st_q == WD_PRE || st_q == WD_RUN));
endmodule

// File: rtl/kwd_counter.sv
`timescale 1ns/1ps
module kwd_counter #(
   parameter int HALF_W = 32,
   parameter int NHALF  = 2
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run_i,
   input  logic                      tick_i,
   input  logic                      clr_i,
   input  logic [NHALF-1:0]          ld_i,
   input  logic [HALF_W-1:0]         ld_val_i,
   input  logic [NHALF*HALF_W-1:0]   period_i,
   output logic [NHALF*HALF_W-1:0]   cnt_o,
   output logic                      hit_o
);
   localparam int CW = NHALF * HALF_W;

   logic [HALF_W-1:0] half_q [NHALF];
   logic [NHALF-1:0]  carry;

   assign carry[0] = run_i & tick_i;

   generate
      for (genvar h = 0; h < NHALF; h++) begin : g_half
         if (h + 1 < NHALF) begin : g_chain
            assign carry[h+1] = carry[h] & (&half_q[h]);
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         half_q[h] <= '0;
            else if (clr_i)     half_q[h] <= '0;
            else if (carry[0]) begin
               if (carry[h]) half_q[h] <= half_q[h] + 1'b1;
            end
            else if (ld_i[h])   half_q[h] <= ld_val_i;
         end
         assign cnt_o[h*HALF_W +: HALF_W] = half_q[h];
      end
   endgenerate

   assign hit_o = carry[0] && (cnt_o == period_i);

   // R6: a ticked, uncleared running cycle adds exactly one
   assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && tick_i && !clr_i) |=> cnt_o == ($past(cnt_o) + CW'(1)));

   // R6: without tick, clear or load the count holds
   assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clr_i && ld_i == '0) |=> $stable(cnt_o));

   // R7: a clear always lands on zero
   assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> cnt_o == '0);
endmodule

// File: rtl/kwd_pulse.sv
`timescale 1ns/1ps
module kwd_pulse #(
   parameter int RST_CYCLES = 16
)(
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic pulse_o
);
   generate
      if (RST_CYCLES == 1) begin : g_flop
         logic p_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) p_q <= 1'b0;
            else        p_q <= fire_i;
         end
         assign pulse_o = p_q;
      end else begin : g_cnt
         localparam int PW = $clog2(RST_CYCLES + 1);
         logic [PW-1:0] c_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          c_q <= '0;
            else if (fire_i)     c_q <= PW'(RST_CYCLES);
            else if (c_q != '0)  c_q <= c_q - 1'b1;
         end
         assign pulse_o = (c_q != '0);
      end
   endgenerate

   // R8: every timeout starts a pulse on the next cycle
   assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> pulse_o);

   // R8: no pulse appears without a timeout
   assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire_i && !pulse_o) |=> !pulse_o);
endmodule

// File: rtl/keyed_wdog.sv
`timescale 1ns/1ps
module keyed_wdog
   import kwd_pkg::*;
#(
   parameter int               ADDR_W     = 6,
   parameter logic [15:0]      KEY_A      = 16'hA5C6,
   parameter logic [15:0]      KEY_B      = 16'hDA7E,
   parameter int               RST_CYCLES = 16,
   parameter logic [31:0]      ID_VALUE   = 32'h4B57_0001
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   output logic              wdog_rst_o
);
   localparam int CW = WD_NH * WD_DW;

   generate
      if (ADDR_W < 6)                          begin : g_chk_addr $error("ADDR_W too small for the register map"); end
      if (KEY_A == KEY_B)                      begin : g_chk_keys $error("the two keys must differ"); end
      if (KEY_A == '0 || KEY_B == '0)          begin : g_chk_zero $error("a key of zero marks a keyless write"); end
      if (RST_CYCLES < 1)                      begin : g_chk_rst  $error("RST_CYCLES must be at least 1"); end
   endgenerate

   wd_state_e state;
   logic locked, running, key_wr, mode_ok;
   logic arm_done, svc_done, bad_key, hit, tmo, clr;
   logic wr_clo, wr_chi, wr_tctl, wr_gctl, wr_wctl;
   logic [WD_NH-1:0] wr_per;
   logic [WD_DW-1:0] per_h [WD_NH];
   logic [CW-1:0]    period, cnt;
   logic [31:0]      tctl_q, gctl_q;
   logic             flag_q;

   assign wr_clo  = wr_i && (addr_i == ADDR_W'(OFF_CLO));
   assign wr_chi  = wr_i && (addr_i == ADDR_W'(OFF_CHI));
   assign wr_tctl = wr_i && (addr_i == ADDR_W'(OFF_TCTL));
   assign wr_gctl = wr_i && (addr_i == ADDR_W'(OFF_GCTL));
   assign wr_wctl = wr_i && (addr_i == ADDR_W'(OFF_WCTL));
   assign wr_per[0] = wr_i && (addr_i == ADDR_W'(OFF_PLO));
   assign wr_per[1] = wr_i && (addr_i == ADDR_W'(OFF_PHI));

   assign locked  = (state != WD_IDLE);
   assign running = (state == WD_RUN) || (state == WD_SVC);
   assign key_wr  = wr_wctl && (wdata_i[31:16] != '0);
   assign mode_ok = (gctl_q[3:0] == GCTL_ARM);

   kwd_keyfsm #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .key_wr_i   (key_wr),
      .key_i      (wdata_i[31:16]),
      .en_bit_i   (wdata_i[BIT_EN]),
      .mode_ok_i  (mode_ok),
      .state_o    (state),
      .arm_done_o (arm_done),
      .svc_done_o (svc_done),
      .bad_key_o  (bad_key)
   );

   assign tmo = hit | bad_key;
   assign clr = arm_done | svc_done | tmo;

   kwd_counter #(.HALF_W(WD_DW), .NHALF(WD_NH)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (running),
      .tick_i   (tick_i),
      .clr_i    (clr),
      .ld_i     ({wr_chi & ~locked, wr_clo & ~locked}),
      .ld_val_i (wdata_i),
      .period_i (period),
      .cnt_o    (cnt),
      .hit_o    (hit)
   );

   kwd_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (tmo),
      .pulse_o (wdog_rst_o)
   );

   generate
      for (genvar h = 0; h < WD_NH; h++) begin : g_per
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    per_h[h] <= '0;
            else if (wr_per[h] && !locked) per_h[h] <= wdata_i;
         end
         assign period[h*WD_DW +: WD_DW] = per_h[h];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tctl_q <= '0;
         gctl_q <= '0;
      end else if (!locked) begin
         if (wr_tctl) tctl_q <= wdata_i;
         if (wr_gctl) gctl_q <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              flag_q <= 1'b0;
      else if (tmo)                            flag_q <= 1'b1;
      else if (wr_wctl && wdata_i[BIT_FLAG])   flag_q <= 1'b0;
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         ADDR_W'(OFF_ID):   rdata_o = ID_VALUE;
         ADDR_W'(OFF_CLO):  rdata_o = cnt[WD_DW-1:0];
         ADDR_W'(OFF_CHI):  rdata_o = cnt[CW-1:WD_DW];
         ADDR_W'(OFF_PLO):  rdata_o = per_h[0];
         ADDR_W'(OFF_PHI):  rdata_o = per_h[1];
         ADDR_W'(OFF_TCTL): rdata_o = tctl_q;
         ADDR_W'(OFF_GCTL): rdata_o = gctl_q;
         ADDR_W'(OFF_WCTL): rdata_o = {16'h0, flag_q, locked, 14'h0};
         default:           rdata_o = '0;
      endcase
   end

   // R5: a locked period ignores bus writes
   assert_period_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && wr_i) |=> $stable(period));

   // R5: a locked global control ignores bus writes
   assert_gctl_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(gctl_q));

   // R7: any timeout leaves the flag set
   assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |=> flag_q);
endmodule

// File: tb/keyed_wdog_tb.sv
`timescale 1ns/1ps
module keyed_wdog_tb;
   localparam logic [31:0] ID_T  = 32'h5157_D0C0;
   localparam int          RSTC  = 4;
   localparam int          NV    = 33;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        wr_i = 1'b0;
   logic [5:0]  addr_i = '0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic        wdog_rst_o;

   int nchk = 0;
   int nbad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   keyed_wdog #(.ADDR_W(6), .RST_CYCLES(RSTC), .ID_VALUE(ID_T)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .wdog_rst_o(wdog_rst_o)
   );

   // {req[3:0], write, addr[7:0], data[31:0], expect[31:0]}
   localparam logic [76:0] VEC [NV] = '{
      {4'd1,  1'b0, 8'h00, 32'h0,         ID_T},          // R1 ID
      {4'd1,  1'b0, 8'h28, 32'h0,         32'h0},         // R1 control
      {4'd1,  1'b0, 8'h04, 32'h0,         32'h0},         // R1 emulation
      {4'd2,  1'b1, 8'h18, 32'h9,         32'h0},         // R2
      {4'd2,  1'b0, 8'h18, 32'h0,         32'h9},
      {4'd2,  1'b1, 8'h10, 32'h1234_5678, 32'h0},
      {4'd2,  1'b0, 8'h10, 32'h0,         32'h1234_5678},
      {4'd2,  1'b1, 8'h14, 32'h0000_CAFE, 32'h0},
      {4'd2,  1'b0, 8'h14, 32'h0,         32'h0000_CAFE},
      {4'd2,  1'b1, 8'h20, 32'h80,        32'h0},
      {4'd2,  1'b0, 8'h20, 32'h0,         32'h80},
      {4'd2,  1'b1, 8'h1C, 32'h0,         32'h0},
      {4'd2,  1'b0, 8'h1C, 32'h0,         32'h0},
      {4'd3,  1'b1, 8'h28, 32'hA5C6_4000, 32'h0},         // R3 global control not set
      {4'd3,  1'b0, 8'h28, 32'h0,         32'h0},
      {4'd2,  1'b1, 8'h24, 32'hB,         32'h0},
      {4'd2,  1'b0, 8'h24, 32'h0,         32'hB},
      {4'd3,  1'b1, 8'h28, 32'hA5C6_0000, 32'h0},         // R3 enable bit missing
      {4'd3,  1'b0, 8'h28, 32'h0,         32'h0},
      {4'd3,  1'b1, 8'h28, 32'hA5C6_4000, 32'h0},         // R3 accepted
      {4'd3,  1'b0, 8'h28, 32'h0,         32'h4000},
      {4'd5,  1'b1, 8'h18, 32'h77,        32'h0},         // R5 period locked
      {4'd5,  1'b0, 8'h18, 32'h0,         32'h9},
      {4'd4,  1'b1, 8'h28, 32'hDA7E_4000, 32'h0},         // R4 start
      {4'd4,  1'b0, 8'h10, 32'h0,         32'h0},
      {4'd4,  1'b0, 8'h14, 32'h0,         32'h0},
      {4'd4,  1'b0, 8'h28, 32'h0,         32'h4000},
      {4'd5,  1'b1, 8'h10, 32'h55,        32'h0},         // R5 counter locked
      {4'd5,  1'b0, 8'h10, 32'h0,         32'h0},
      {4'd5,  1'b1, 8'h24, 32'h0,         32'h0},
      {4'd5,  1'b0, 8'h24, 32'h0,         32'hB},
      {4'd5,  1'b1, 8'h20, 32'h0,         32'h0},
      {4'd5,  1'b0, 8'h20, 32'h0,         32'h80}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_i = 1'b1; addr_i = a[5:0]; wdata_i = d;
      @(negedge clk);
      wr_i = 1'b0; wdata_i = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr_i = a[5:0];
      #1;
      d = rdata_o;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic arm(input logic [31:0] plo, input logic [31:0] phi);
      wr(8'h18, plo);
      wr(8'h1C, phi);
      wr(8'h24, 32'hB);
      wr(8'h28, 32'hA5C6_4000);
      wr(8'h28, 32'hDA7E_4000);
   endtask

   task automatic cycles_to_rst(output int n);
      n = 0;
      while (!wdog_rst_o && n < 5000) begin
         @(posedge clk); #1;
         n++;
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int n;
      repeat (3) @(negedge clk);
      chk("R1 reset output", {63'h0, wdog_rst_o}, 64'h0);
      rst_n = 1'b1;

      // register table, tick low so the counter stays still
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][72]) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
         end else begin
            rd(VEC[i][71:64], d);
            chk($sformatf("R%0d vector %0d", VEC[i][76:73], i), {32'h0, d}, {32'h0, VEC[i][31:0]});
         end
      end

      // R7, R8: period 5 fires after 6 ticked cycles, pulse lasts RSTC
      do_reset();
      tick_i = 1'b1;
      arm(32'd5, 32'd0);
      cycles_to_rst(n);
      chk("R7 cycles to timeout P=5", n, 6);
      n = 0;
      while (wdog_rst_o && n < 100) begin n++; @(posedge clk); #1; end
      chk("R8 pulse length", n, RSTC);
      rd(8'h28, d);
      chk("R7 flag set", d, 32'hC000);

      // R7 boundary: period zero fires on the first tick
      do_reset();
      arm(32'd0, 32'd0);
      cycles_to_rst(n);
      chk("R7 cycles to timeout P=0", n, 1);

      // R9: service restarts the count
      do_reset();
      arm(32'd10, 32'd0);
      repeat (6) @(negedge clk);
      wr(8'h28, 32'hA5C6_0000);
      chk("R9 no timeout in service", {63'h0, wdog_rst_o}, 64'h0);
      wr(8'h28, 32'hDA7E_0000);
      rd(8'h10, d);
      chk("R9 counter cleared", d, 32'h0);
      cycles_to_rst(n);
      chk("R9 cycles after service", n, 11);

      // R10: wrong key forces a timeout; R11 flag clear; R12 no disarm
      do_reset();
      arm(32'd1000, 32'd0);
      wr(8'h28, 32'h1234_0000);
      chk("R10 bad key timeout", {63'h0, wdog_rst_o}, 64'h1);
      rd(8'h28, d);
      chk("R10 flag after bad key", d, 32'hC000);
      wr(8'h28, 32'h0000_8000);
      rd(8'h28, d);
      chk("R11 flag cleared while locked", d, 32'h4000);
      repeat (6) @(negedge clk);
      wr(8'h28, 32'h0000_0000);
      rd(8'h28, d);
      chk("R12 enable not cleared", d, 32'h4000);
      repeat (3) @(negedge clk);
      chk("R10 keyless write no timeout", {63'h0, wdog_rst_o}, 64'h0);

      // R6: no tick, no count
      do_reset();
      tick_i = 1'b0;
      arm(32'd3, 32'd0);
      repeat (20) @(negedge clk);
      chk("R6 no timeout without tick", {63'h0, wdog_rst_o}, 64'h0);
      rd(8'h10, d);
      chk("R6 counter held", d, 32'h0);
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
      rd(8'h10, d);
      chk("R6 one tick one step", d, 32'h1);

      // R7: high half of the period takes part in the compare
      do_reset();
      tick_i = 1'b1;
      arm(32'd3, 32'd1);
      repeat (20) @(negedge clk);
      chk("R7 high half delays timeout", {63'h0, wdog_rst_o}, 64'h0);
      rd(8'h10, d);
      chk("R7 counter low after 20", d, 32'd20);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end
endmodule